// File: doc/BRIEF.md
# Read Completion Splitter

This block turns one memory read request into the ordered list of completion descriptors that return its data. A request gives a start byte address, a length in dwords and a payload size code. The block then issues one descriptor per chunk. Each descriptor carries the chunk's byte address, its byte length, the count of bytes still owed including this chunk, and the low seven address bits for the completion header. The last descriptor of a request is flagged.

Chunk size is the smallest of three limits. The first is the bytes still owed. The second is the payload limit, which is 128 bytes shifted left by the size code. The third is the room left before the next 4 KB address boundary. A chunk longer than 128 bytes is also cut back so that it ends on a 128-byte completion boundary. Both sides use valid/ready handshakes. While a request is in progress, no new request is taken.

Top module: `rd_cpl_splitter`

## Requirements
- R1: An accepted request of N dwords (1 <= N < 2^LEN_W) produces chunks whose lengths add up to exactly 4*N bytes, and the first descriptor's byte count equals 4*N.
- R2: No chunk is longer than 128 << code bytes, where code is the size code taken with the request; codes 6 and 7 are treated as 5 (4096 bytes).
- R3: A candidate chunk longer than 128 bytes is shortened by (address + length) mod 128, so every chunk longer than 128 bytes that is not the last ends on a 128-byte boundary.
- R4: No chunk crosses a 4 KB boundary: address[11:0] + length never exceeds 4096.
- R5: cpl_byte_cnt_o is the number of bytes still outstanding, including the current chunk, and drops by the chunk length after each accepted descriptor.
- R6: cpl_addr_o is the chunk's byte address, starting at the request address, and cpl_lower_addr_o equals its bits [6:0].
- R7: After each accepted descriptor the address advances by the chunk length. cpl_last_o is high exactly on the descriptor whose length equals the byte count, and cpl_valid_o falls in the cycle after that descriptor is taken.
- R8: req_ready_o is low from the cycle after a request is accepted until its last descriptor has been taken. A request offered in that time is ignored.
- R9: While cpl_valid_o is high and cpl_ready_i is low, cpl_valid_o stays high and all descriptor fields hold their values.
- R10: Asserting rst_ni low clears cpl_valid_o, drops any request in progress and leaves req_ready_o high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Read request offered |
| req_ready_o | output | 1 | Splitter idle, request can be taken |
| req_addr_i | input | ADDR_W | Start byte address of the read |
| req_len_dw_i | input | LEN_W | Read length in dwords, nonzero |
| req_mps_i | input | 3 | Payload size code, limit is 128 << code bytes |
| cpl_valid_o | output | 1 | Completion descriptor valid |
| cpl_ready_i | input | 1 | Descriptor taken by consumer |
| cpl_addr_o | output | ADDR_W | Byte address of the chunk |
| cpl_len_o | output | LEN_W+2 | Chunk length in bytes |
| cpl_byte_cnt_o | output | LEN_W+2 | Bytes outstanding including this chunk |
| cpl_lower_addr_o | output | 7 | Chunk address bits [6:0] |
| cpl_last_o | output | 1 | Final descriptor of the request |

## Verification
The assertions assume that an accepted request never has a zero dword count, and one assertion checks this at the request port. They also assume that addresses stay within ADDR_W with no wrap past the top of the space. The directed stimulus uses only nonzero lengths and addresses far below the top of the space. Its requests are placed so that payload cuts, boundary trims, 4 KB splits and oversized size codes each occur in a known chunk. Stalls and overlapping requests are driven only while a descriptor is pending, which is the window where the hold and ignore properties apply.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  localparam int unsigned RCB_LOG2  = 7;
  localparam int unsigned PAGE_LOG2 = 12;
  localparam logic [2:0]  MPS_CODE_MAX = 3'd5;
endpackage

// File: rtl/rcs_chunk_calc.sv
module rcs_chunk_calc import rcs_pkg::*; #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 13
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  remain_i,
  input  logic [2:0]        mps_code_i,
  output logic [CNT_W-1:0]  chunk_o
);
  localparam int unsigned CW = (CNT_W > PAGE_LOG2 + 1) ? CNT_W : PAGE_LOG2 + 1;
  localparam logic [CW-1:0] RCB_B  = CW'(1) << RCB_LOG2;
  localparam logic [PAGE_LOG2:0] PAGE_B = (PAGE_LOG2+1)'(1) << PAGE_LOG2;

  logic [2:0]          code_c;
  logic [CW-1:0]       mps_b, rem_w, cand, trimmed, room, chunk_w;
  logic [RCB_LOG2-1:0] tail;
  logic [PAGE_LOG2:0]  room_p;

  always_comb begin
    code_c  = (mps_code_i > MPS_CODE_MAX) ? MPS_CODE_MAX : mps_code_i;
    mps_b   = RCB_B << code_c;
    rem_w   = CW'(remain_i);
    cand    = (rem_w < mps_b) ? rem_w : mps_b;
    // end position modulo the completion boundary
    tail    = addr_i[RCB_LOG2-1:0] + cand[RCB_LOG2-1:0];
    trimmed = (cand > RCB_B) ? cand - CW'(tail) : cand;
    room_p  = PAGE_B - {1'b0, addr_i[PAGE_LOG2-1:0]};
    room    = CW'(room_p);
    chunk_w = (trimmed < room) ? trimmed : room;
    chunk_o = CNT_W'(chunk_w);
  end
endmodule

// File: rtl/rcs_seq_ctrl.sv
module rcs_seq_ctrl #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  bytes_i,
  input  logic [2:0]        mps_i,
  input  logic              take_i,
  input  logic [CNT_W-1:0]  chunk_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic [CNT_W-1:0]  remain_o,
  output logic [2:0]        mps_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o     <= 1'b0;
      cur_addr_o <= '0;
      remain_o   <= '0;
      mps_o      <= '0;
    end else if (start_i) begin
      busy_o     <= 1'b1;
      cur_addr_o <= addr_i;
      remain_o   <= bytes_i;
      mps_o      <= mps_i;
    end else if (take_i) begin
      cur_addr_o <= cur_addr_o + ADDR_W'(chunk_i);
      remain_o   <= remain_o - chunk_i;
      if (chunk_i == remain_o) busy_o <= 1'b0;
    end
  end

  // R1
  nonzero_chunk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (chunk_i != '0) && (chunk_i <= remain_o));
  // R8
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !start_i);
endmodule

// File: rtl/rd_cpl_splitter.sv
module rd_cpl_splitter import rcs_pkg::*; #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [LEN_W-1:0]   req_len_dw_i,
  input  logic [2:0]         req_mps_i,
  output logic               cpl_valid_o,
  input  logic               cpl_ready_i,
  output logic [ADDR_W-1:0]  cpl_addr_o,
  output logic [LEN_W+1:0]   cpl_len_o,
  output logic [LEN_W+1:0]   cpl_byte_cnt_o,
  output logic [6:0]         cpl_lower_addr_o,
  output logic               cpl_last_o
);
  localparam int unsigned CNT_W = LEN_W + 2;

  logic              busy, start, take;
  logic [ADDR_W-1:0] cur_addr;
  logic [CNT_W-1:0]  remain, chunk, req_bytes;
  logic [2:0]        mps_q;

  assign req_bytes   = {req_len_dw_i, 2'b00};
  assign req_ready_o = !busy;
  assign start       = req_valid_i && req_ready_o;
  assign take        = cpl_valid_o && cpl_ready_i;

  rcs_seq_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_seq (
    .clk_i, .rst_ni,
    .start_i(start), .addr_i(req_addr_i), .bytes_i(req_bytes), .mps_i(req_mps_i),
    .take_i(take), .chunk_i(chunk),
    .busy_o(busy), .cur_addr_o(cur_addr), .remain_o(remain), .mps_o(mps_q)
  );

  rcs_chunk_calc #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_calc (
    .addr_i(cur_addr), .remain_i(remain), .mps_code_i(mps_q), .chunk_o(chunk)
  );

  assign cpl_valid_o      = busy;
  assign cpl_addr_o       = cur_addr;
  assign cpl_len_o        = chunk;
  assign cpl_byte_cnt_o   = remain;
  assign cpl_lower_addr_o = cur_addr[6:0];
  assign cpl_last_o       = busy && (chunk == remain);

  // R1
  req_len_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |-> req_len_dw_i != '0);
  // R1
  first_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> cpl_valid_o && cpl_byte_cnt_o == {$past(req_len_dw_i), 2'b00});
  // R2
  mps_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_valid_o |-> 32'(cpl_len_o) <= (32'd128 << ((mps_q > MPS_CODE_MAX) ? MPS_CODE_MAX : mps_q)));
  // R3
  rcb_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpl_valid_o && !cpl_last_o && cpl_len_o > (LEN_W+2)'(128))
      |-> (cpl_lower_addr_o + cpl_len_o[6:0]) == 7'd0);
  // R4
  page_cross_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_valid_o |-> (32'(cpl_addr_o[PAGE_LOG2-1:0]) + 32'(cpl_len_o)) <= 32'd4096);
  // R5
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !cpl_last_o) |=> cpl_byte_cnt_o == $past(cpl_byte_cnt_o) - $past(cpl_len_o));
  // R7
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !cpl_last_o) |=> cpl_addr_o == $past(cpl_addr_o) + ADDR_W'($past(cpl_len_o)));
  // R7
  end_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && cpl_last_o) |=> !cpl_valid_o);
  // R8
  ready_while_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_valid_o |-> !req_ready_o);
  // R9
  hold_on_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpl_valid_o && !cpl_ready_i) |=> cpl_valid_o && $stable(cpl_addr_o)
      && $stable(cpl_len_o) && $stable(cpl_byte_cnt_o) && $stable(cpl_last_o));
endmodule

// File: tb/test_rd_cpl_splitter.sv
module test_rd_cpl_splitter;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 11;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_valid = 1'b0, cpl_ready = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LEN_W-1:0]  req_len = '0;
  logic [2:0]        req_mps = '0;
  logic req_ready, cpl_valid, cpl_last;
  logic [ADDR_W-1:0] cpl_addr;
  logic [LEN_W+1:0]  cpl_len, cpl_cnt;
  logic [6:0]        cpl_lo;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rd_cpl_splitter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_rd_cpl_splitter (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .req_len_dw_i(req_len), .req_mps_i(req_mps),
    .cpl_valid_o(cpl_valid), .cpl_ready_i(cpl_ready), .cpl_addr_o(cpl_addr),
    .cpl_len_o(cpl_len), .cpl_byte_cnt_o(cpl_cnt), .cpl_lower_addr_o(cpl_lo),
    .cpl_last_o(cpl_last)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int exp_chunk(int a, int rem, int code);
    int mps, c, room;
    mps  = 128 << ((code > 5) ? 5 : code);
    c    = (rem < mps) ? rem : mps;
    if (c > 128) c = c - ((a + c) % 128);
    room = 4096 - (a % 4096);
    if (c > room) c = room;
    return c;
  endfunction

  // Offers a request, then walks every descriptor against the model.
  task automatic run_req(input int a, input int ldw, input int code, input bit stall);
    int ea = a, rem = ldw * 4, c, total = 0, guard = 0;
    bit first = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R8", "ready when idle", req_ready, 1);
    req_valid = 1'b1; req_addr = ADDR_W'(a); req_len = LEN_W'(ldw); req_mps = 3'(code);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R8", "ready while busy", req_ready, 0);
    while (rem > 0 && guard < 200) begin
      guard++;
      c = exp_chunk(ea, rem, code);
      if (first) chk(int'(cpl_cnt) == ldw * 4, "R1", "first byte count", cpl_cnt, ldw * 4);
      if (stall && first) begin
        cpl_ready = 1'b0;
        req_valid = 1'b1; req_addr = 32'h00DE_AD00; req_len = 11'd7; req_mps = 3'd1;
        for (int k = 0; k < 3; k++) begin
          @(negedge clk);
          chk(cpl_valid == 1'b1, "R9", "valid held", cpl_valid, 1);
          chk(int'(cpl_len) == c, "R9", "len held", cpl_len, c);
          chk(int'(cpl_addr) == ea, "R9", "addr held", cpl_addr, ea);
          chk(req_ready == 1'b0, "R8", "busy ignores request", req_ready, 0);
        end
        req_valid = 1'b0;
      end
      first = 1'b0;
      chk(cpl_valid == 1'b1, "R7", "valid", cpl_valid, 1);
      chk(int'(cpl_len) == c, "R2/R3/R4", "chunk length", cpl_len, c);
      chk(int'(cpl_cnt) == rem, "R5", "byte count", cpl_cnt, rem);
      chk(int'(cpl_addr) == ea, "R6", "chunk address", cpl_addr, ea);
      chk(int'(cpl_lo) == (ea % 128), "R6", "lower address", cpl_lo, ea % 128);
      chk(cpl_last == (c == rem), "R7", "last flag", cpl_last, (c == rem));
      cpl_ready = 1'b1;
      @(negedge clk);
      cpl_ready = 1'b0;
      ea += c; rem -= c; total += c;
    end
    chk(total == ldw * 4, "R1", "bytes sent", total, ldw * 4);
    chk(cpl_valid == 1'b0, "R7", "idle after last", cpl_valid, 0);
    chk(req_ready == 1'b1, "R8", "ready after last", req_ready, 1);
  endtask

  task automatic t_reset_state;
    chk(cpl_valid == 1'b0, "R10", "valid in reset", cpl_valid, 0);
    chk(req_ready == 1'b1, "R10", "ready in reset", req_ready, 1);
  endtask

  task automatic t_single;      run_req(32'h100, 4, 0, 1'b0);    endtask
  task automatic t_mps_split;   run_req(32'h0, 128, 0, 1'b0);    endtask
  task automatic t_rcb_trim;    run_req(32'h1044, 96, 1, 1'b0);  endtask
  task automatic t_page_split;  run_req(32'h0FC0, 64, 2, 1'b0);  endtask
  task automatic t_full_page;   run_req(32'h2000, 1024, 5, 1'b0); endtask
  task automatic t_code_clamp;  run_req(32'h3000, 1000, 7, 1'b0); endtask // R2 code 7 acts as 5
  task automatic t_odd_addr;    run_req(32'h5FF3, 300, 3, 1'b0); endtask
  task automatic t_stall;       run_req(32'h0E80, 100, 1, 1'b1); endtask

  task automatic t_mid_reset;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h0; req_len = 11'd256; req_mps = 3'd0;
    @(negedge clk);
    req_valid = 1'b0; cpl_ready = 1'b1;
    @(negedge clk);
    cpl_ready = 1'b0;
    chk(int'(cpl_addr) == 128, "R7", "address advanced", cpl_addr, 128);
    rst_ni = 1'b0;
    @(negedge clk);
    chk(cpl_valid == 1'b0, "R10", "valid cleared", cpl_valid, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(cpl_valid == 1'b0, "R10", "request dropped", cpl_valid, 0);
    chk(req_ready == 1'b1, "R10", "ready after reset", req_ready, 1);
    run_req(32'h40, 2, 0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_ni = 1'b1;
    @(negedge clk);
    t_single();
    t_mps_split();
    t_rcb_trim();
    t_page_split();
    t_full_page();
    t_code_clamp();
    t_odd_addr();
    t_stall();
    t_mid_reset();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule